// File: doc/BRIEF.md
# Display Interrupt Control and Status Register

This block is one 32-bit word that gathers the interrupt controls of a display pipe. A vertical-blank level arrives from the timing generator. The word shows that level as a live status bit. On each rising edge of the level it latches two sticky flags, one for vertical blank and one for vertical line. Software writes the word over a simple register bus with per-byte enables.

Within one write, three kinds of bit follow different rules:
- Read-only bits keep their value whatever is written.
- A flag bit is cleared by writing a 1 to it and is left alone by a 0.
- Every other bit is plain storage.

Two enable bits decide whether the blank level is passed to the level interrupt output.

The read word is combinational from the stored bits and the live blank level. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `disp_irq_ctrl`

## Requirements
- R1: Bit 0 of `rd_data` always equals `blank_in`, with no clock delay. Writes to bit 0 have no effect on it.
- R2: Bits 1 and 2 are read-only status bits with no source in this block. They read 0 after reset, and no write ever changes them.
- R3: A rising edge of `blank_in` is detected at a clock edge where `blank_in` is 1 and was 0 at the previous edge. The detector's previous value is 0 after reset. The rising edge sets both sticky flags, bit 4 (vertical blank) and bit 5 (vertical line), at that same clock edge. While the level stays high, the flags are not set again.
- R4: A write with the flag's byte lane enabled (`wr_be[0]` for bits 4 and 5) and a 1 in the flag bit clears that flag.
- R5: A write that has a 0 in a flag bit leaves that flag unchanged. So does a write whose flag lane is not enabled.
- R6: All bits other than 0, 1, 2, 4 and 5 take the written value in enabled byte lanes. This includes bit 8 (vertical-blank enable) and bit 9 (vertical-line enable).
- R7: Byte lanes whose `wr_be` bit is 0 keep their previous value in every bit.
- R8: `irq_out` equals `blank_in` when bit 8 or bit 9 is 1. Otherwise it is 0.
- R9: When a rising edge and an acknowledge write of a flag fall on the same clock edge, the flag ends up set.
- R10: While `rst_n` is low, every stored bit is 0. `rd_data` then reads only the live bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current word, live bit included |
| blank_in | input | 1 | Vertical-blank level from the timing generator |
| irq_out | output | 1 | Level interrupt output |

## Verification
A flag can be set by a blank rising edge and acknowledged by a bus write on the same clock edge. The bench provokes this directly by driving a write of ones to lane 0 in the very cycle that `blank_in` first rises, and judges that both flags read 1 afterwards. The same collision also arises many times under random stimulus. There, a bench model that applies the event after the acknowledge predicts every word.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
   localparam int unsigned LANE_W = 8;

   function automatic logic [31:0] bit_mask(input int unsigned pos);
      return 32'(1) << pos;
   endfunction
endpackage

// File: rtl/disp_irq_edge.sv
module disp_irq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_in;
   end

   assign rise = level_in & ~level_q;
endmodule

// File: rtl/disp_irq_lanes.sv
module disp_irq_lanes #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / disp_irq_pkg::LANE_W
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] lane_mask
);
   localparam int unsigned LW = disp_irq_pkg::LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[g*LW +: LW] = {LW{be[g]}};
      assign merged[g*LW +: LW]    = be[g] ? wdata[g*LW +: LW] : cur[g*LW +: LW];
   end
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BLANK_STS = 0,
   parameter int unsigned LSYNC_STS = 1,
   parameter int unsigned FRAME_STS = 2,
   parameter int unsigned VB_FLAG   = 4,
   parameter int unsigned VL_FLAG   = 5,
   parameter int unsigned VB_EN     = 8,
   parameter int unsigned VL_EN     = 9,
   localparam int unsigned LANES    = DATA_W / disp_irq_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              blank_in,
   output logic              irq_out
);
   import disp_irq_pkg::*;

   localparam logic [DATA_W-1:0] RO_MASK  = DATA_W'(bit_mask(BLANK_STS) | bit_mask(LSYNC_STS) | bit_mask(FRAME_STS));
   localparam logic [DATA_W-1:0] ACK_MASK = DATA_W'(bit_mask(VB_FLAG) | bit_mask(VL_FLAG));
   localparam logic [DATA_W-1:0] RW_MASK  = ~(RO_MASK | ACK_MASK);
   localparam logic [DATA_W-1:0] EVT_MASK = ACK_MASK;

   if (DATA_W % LANE_W != 0 || DATA_W > 32) begin : g_bad_width
      $error("DATA_W must be a multiple of the lane width and at most 32");
   end
   if (VB_FLAG >= DATA_W || VL_FLAG >= DATA_W || VB_EN >= DATA_W || VL_EN >= DATA_W) begin : g_bad_pos
      $error("bit position outside the word");
   end

   logic [DATA_W-1:0] word_q, word_d, merged, lane_mask, ack_hit;
   logic rise;

   disp_irq_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (blank_in),
      .rise     (rise)
   );

   disp_irq_lanes #(.DATA_W(DATA_W)) u_lanes (
      .cur       (word_q),
      .wdata     (wr_data),
      .be        (wr_be),
      .merged    (merged),
      .lane_mask (lane_mask)
   );

   assign ack_hit = wr_data & lane_mask & ACK_MASK;

   always_comb begin
      word_d = word_q;
      if (wr_en)
         word_d = (word_q & RO_MASK) | (word_q & ACK_MASK & ~ack_hit) | (merged & RW_MASK);
      if (rise)
         word_d = word_d | EVT_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   always_comb begin
      rd_data            = word_q;
      rd_data[BLANK_STS] = blank_in;
   end

   assign irq_out = blank_in & (word_q[VB_EN] | word_q[VL_EN]);

   localparam int unsigned FL_LANE = VB_FLAG / LANE_W;
   localparam int unsigned EN_LANE = VB_EN / LANE_W;

   assert_ro_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> $stable(rd_data[FRAME_STS:LSYNC_STS]));

   assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (rd_data[VB_FLAG] && rd_data[VL_FLAG]));

   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[FL_LANE] && wr_data[VB_FLAG] && !rise) |=> !rd_data[VB_FLAG]);

   assert_ack_zero_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[VL_FLAG] && rd_data[VL_FLAG]) |=> rd_data[VL_FLAG]);

   assert_lane_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be[EN_LANE]) |=> $stable(rd_data[VL_EN:VB_EN]));

   assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_in |-> !irq_out);

   assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && wr_en) |=> rd_data[VL_FLAG]);
endmodule

// File: tb/disp_irq_ctrl_test.sv
`timescale 1ns/100ps
module disp_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_be;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        blank_in;
   logic        irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] model;
   logic        prev_blank;

   always #2.5 clk = ~clk;

   disp_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
      .wr_data(wr_data), .rd_data(rd_data), .blank_in(blank_in), .irq_out(irq_out)
   );

   function automatic logic [31:0] next_word(input logic [31:0] cur, input logic we,
      input logic [3:0] be, input logic [31:0] d, input logic rise);
      logic [31:0] n = cur;
      for (int i = 0; i < 32; i++) begin
         if (we && be[i/8]) begin
            if (i == 4 || i == 5) begin
               if (d[i]) n[i] = 1'b0;
            end else if (i > 2) begin
               n[i] = d[i];
            end
         end
      end
      if (rise) begin
         n[4] = 1'b1;
         n[5] = 1'b1;
      end
      return n;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycle(input logic we, input logic [3:0] be, input logic [31:0] d, input logic bl);
      @(negedge clk);
      wr_en = we; wr_be = be; wr_data = d; blank_in = bl;
      @(posedge clk);
      model = next_word(model, we, be, d, bl & ~prev_blank);
      prev_blank = bl;
      #1;
      wr_en = 1'b0;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] exp;
      exp = model;
      exp[0] = blank_in;
      check({tag, " R1 live bit"}, {31'b0, rd_data[0]}, {31'b0, blank_in});
      check({tag, " R2 ro bits"}, {30'b0, rd_data[2:1]}, 32'b0);
      check({tag, " R3 R4 R5 R6 R7 R9 word"}, rd_data, exp);
      check({tag, " R8 irq"}, {31'b0, irq_out},
            {31'b0, blank_in & (model[8] | model[9])});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; wr_en = 1'b0; wr_be = 4'h0; wr_data = '0; blank_in = 1'b0;
      model = '0; prev_blank = 1'b0;
      @(negedge clk); wr_en = 1'b1; wr_be = 4'hf; wr_data = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset word", rd_data, 32'h0);
      @(negedge clk); wr_en = 1'b0; rst_n = 1'b1;

      cycle(1'b1, 4'hf, 32'hffff_ffff, 1'b0);
      check("R2 R6 all ones write", rd_data, 32'hffff_ffc8);
      cycle(1'b1, 4'hf, 32'h0000_0000, 1'b0);
      check("R6 zero write", rd_data, 32'h0);
      cycle(1'b0, 4'h0, 32'h0, 1'b1);
      check("R3 rise sets both flags", rd_data, 32'h0000_0031);
      check("R8 irq off with enables clear", {31'b0, irq_out}, 32'h0);
      cycle(1'b1, 4'h1, 32'h0000_0010, 1'b1);
      check("R4 ack vb flag", rd_data, 32'h0000_0021);
      cycle(1'b0, 4'h0, 32'h0, 1'b1);
      check("R3 no reset while level high", rd_data, 32'h0000_0021);
      cycle(1'b1, 4'h1, 32'h0000_0000, 1'b1);
      check("R5 zero keeps flag", rd_data, 32'h0000_0021);
      cycle(1'b1, 4'he, 32'h0000_0020, 1'b1);
      check("R5 lane off keeps flag", rd_data, 32'h0000_0021);
      cycle(1'b1, 4'h2, 32'h0000_0100, 1'b1);
      check("R8 irq follows blank with vb enable", {31'b0, irq_out}, 32'h1);
      cycle(1'b1, 4'h1, 32'h0000_0020, 1'b0);
      check("R1 live bit low", rd_data, 32'h0000_0100);
      check("R8 irq low with blank low", {31'b0, irq_out}, 32'h0);
      cycle(1'b1, 4'h1, 32'h0000_0031, 1'b1);
      check("R9 event wins over ack", rd_data, 32'h0000_0131);
      cycle(1'b1, 4'h2, 32'h0000_0200, 1'b1);
      check("R8 irq with vl enable", {31'b0, irq_out}, 32'h1);
      cycle(1'b1, 4'h5, 32'h00ab_cd30, 1'b1);
      check("R7 lanes 1 and 3 kept", rd_data, 32'h00ab_0201);

      for (int i = 0; i < 400; i++) begin
         cycle(1'($urandom), 4'($urandom), $urandom, ($urandom % 3) == 0);
         check_all("random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule